// File: doc/BRIEF.md
# Signed Radix-4 Digit to Binary Converter

This block takes a number written as N signed radix-4 digits and returns the same value as an ordinary two's-complement integer. Each digit sits in its own 3-bit two's-complement field and may hold any value from -3 to +3. An optional signed carry digit, such as the one a redundant-digit adder produces at its top end, is folded in with weight 4^N. The block also raises an error flag when any field holds a code that is not a legal digit.

The conversion is purely combinational up to a single register stage. Inputs are sampled on a rising clock edge while the input strobe is high. One cycle later the result and the error flag appear together with an output strobe. While the strobe is low the registered result is held unchanged. A typical use is to sit behind a redundant-digit adder and turn its sum into binary for later stages.

Top module: `sdq2bin_conv`

## Requirements
- R1: Digit i lies in bits 3i+2..3i of `in_digits`, with digit 0 at the least significant end. Each field is read as 3-bit two's complement and sign-extended to the result width. The result is the sum of d_i * 4^i over all digits.
- R2: Carry code 2'b01 adds 4^N, carry code 2'b11 subtracts 4^N, and carry code 2'b00 adds nothing. With N = 4 this is +256 or -256.
- R3: A digit field holding 3'b100 is illegal. It sets `out_err` for that transaction and contributes zero to the result.
- R4: Carry code 2'b10 is illegal. It sets `out_err` for that transaction and contributes zero to the result.
- R5: `out_err` is not sticky. A transaction whose digits and carry are all legal yields `out_err` = 0, whatever came before it.
- R6: `out_vld` equals `in_vld` from the previous clock edge. Every accepted transaction produces exactly one result, one cycle later.
- R7: While `in_vld` is low, `out_value` and `out_err` keep their values, whatever the other inputs do.
- R8: A synchronous active-high `rst` clears `out_vld`, `out_value` and `out_err` to zero, even when `in_vld` is high.
- R9: The digit count N must lie between 1 and 14, so that 4^(N+1) still fits in the 32-bit signed result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input strobe; the inputs are captured while it is high |
| in_digits | input | 3*NDIG | Packed signed radix-4 digits, digit 0 in bits 2..0 |
| in_carry | input | 2 | Signed carry digit with weight 4^NDIG |
| out_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| out_value | output | RES_W | Two's-complement result |
| out_err | output | 1 | An illegal digit or carry code was present in the captured transaction |

## Verification
The assertions check the following properties on every cycle:
- The strobe delay and the reset clearing.
- That idle cycles leave the result and the flag untouched.
- That an illegal digit or carry always raises the flag and that fully legal input never does.
- The exact weight of a lone carry digit.

The assertions cannot confirm that the digit weighting and summation are right. The bench shows this with its scenarios: an exhaustive sweep of every legal four-digit pattern under each legal carry code, illegal codes in every digit position, and a reset that arrives while a transaction is being presented.

// File: rtl/sdq_pkg.sv
`timescale 1ns/1ps
package sdq_pkg;
    localparam int DIG_W = 3;
    localparam int CY_W  = 2;

    localparam logic [DIG_W-1:0] DIG_ILLEGAL = 3'b100;

    typedef enum logic [CY_W-1:0] {
        CY_ZERO = 2'b00,
        CY_POS  = 2'b01,
        CY_BAD  = 2'b10,
        CY_NEG  = 2'b11
    } cy_code_e;
endpackage

// File: rtl/sdq_digit_term.sv
`timescale 1ns/1ps
// One weighted digit: sign-extend the 3-bit field, shift by 2*POS.
module sdq_digit_term
    import sdq_pkg::*;
#(
    parameter int RES_W = 32,
    parameter int POS   = 0
) (
    input  logic [DIG_W-1:0]        dig_i,
    output logic signed [RES_W-1:0] term_o,
    output logic                    bad_o
);
    localparam int SHIFT = 2 * POS;

    logic signed [RES_W-1:0] ext;

    always_comb begin
        bad_o  = (dig_i == DIG_ILLEGAL);
        ext    = {{(RES_W-DIG_W){dig_i[DIG_W-1]}}, dig_i};
        term_o = bad_o ? '0 : (ext <<< SHIFT);
    end
endmodule

// File: rtl/sdq_carry_term.sv
`timescale 1ns/1ps
// Carry digit decoded to +/- 4^NDIG, illegal code gives zero and a flag.
module sdq_carry_term
    import sdq_pkg::*;
#(
    parameter int RES_W = 32,
    parameter int NDIG  = 4
) (
    input  logic [CY_W-1:0]         cy_i,
    output logic signed [RES_W-1:0] term_o,
    output logic                    bad_o
);
    localparam int SHIFT = 2 * NDIG;
    localparam logic signed [RES_W-1:0] UNIT = {{(RES_W-1){1'b0}}, 1'b1} <<< SHIFT;

    always_comb begin
        bad_o  = 1'b0;
        term_o = '0;
        case (cy_code_e'(cy_i))
            CY_POS:  term_o = UNIT;
            CY_NEG:  term_o = -UNIT;
            CY_BAD:  bad_o  = 1'b1;
            default: term_o = '0;
        endcase
    end
endmodule

// File: rtl/sdq_term_sum.sv
`timescale 1ns/1ps
// Adds NTERM packed signed terms.
module sdq_term_sum #(
    parameter int RES_W = 32,
    parameter int NTERM = 5
) (
    input  logic [NTERM*RES_W-1:0]  terms_i,
    output logic signed [RES_W-1:0] sum_o
);
    always_comb begin
        sum_o = '0;
        for (int k = 0; k < NTERM; k++) begin
            sum_o = sum_o + $signed(terms_i[k*RES_W +: RES_W]);
        end
    end
endmodule

// File: rtl/sdq2bin_conv.sv
`timescale 1ns/1ps
module sdq2bin_conv
    import sdq_pkg::*;
#(
    parameter int NDIG  = 4,
    parameter int RES_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_vld,
    input  logic [NDIG*DIG_W-1:0]   in_digits,
    input  logic [CY_W-1:0]         in_carry,
    output logic                    out_vld,
    output logic signed [RES_W-1:0] out_value,
    output logic                    out_err
);
    localparam int NTERM = NDIG + 1;

    typedef struct packed {
        logic                    vld;
        logic                    err;
        logic signed [RES_W-1:0] val;
    } stage_t;

    logic [NTERM*RES_W-1:0]  terms;
    logic [NTERM-1:0]        bad;
    logic signed [RES_W-1:0] total;
    stage_t                  st_d;
    stage_t                  st_q;

    // Digit terms, one per position.
    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        sdq_digit_term #(
            .RES_W(RES_W),
            .POS  (g)
        ) u_dig (
            .dig_i (in_digits[g*DIG_W +: DIG_W]),
            .term_o(terms[g*RES_W +: RES_W]),
            .bad_o (bad[g])
        );
    end

    // Carry term in the top slot.
    sdq_carry_term #(
        .RES_W(RES_W),
        .NDIG (NDIG)
    ) u_cy (
        .cy_i  (in_carry),
        .term_o(terms[NDIG*RES_W +: RES_W]),
        .bad_o (bad[NDIG])
    );

    sdq_term_sum #(
        .RES_W(RES_W),
        .NTERM(NTERM)
    ) u_sum (
        .terms_i(terms),
        .sum_o  (total)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.val = total;
            st_d.err = |bad;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld   = st_q.vld;
    assign out_value = st_q.val;
    assign out_err   = st_q.err;
endmodule

// File: rtl/sdq2bin_chk.sv
`timescale 1ns/1ps
module sdq2bin_chk
    import sdq_pkg::*;
#(
    parameter int NDIG  = 4,
    parameter int RES_W = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_vld,
    input logic [NDIG*DIG_W-1:0]   in_digits,
    input logic [CY_W-1:0]         in_carry,
    input logic                    out_vld,
    input logic signed [RES_W-1:0] out_value,
    input logic                    out_err
);
    localparam logic signed [RES_W-1:0] CY_UNIT = {{(RES_W-1){1'b0}}, 1'b1} <<< (2 * NDIG);

    logic any_bad_dig;

    always_comb begin
        any_bad_dig = 1'b0;
        for (int k = 0; k < NDIG; k++) begin
            if (in_digits[k*DIG_W +: DIG_W] == DIG_ILLEGAL) any_bad_dig = 1'b1;
        end
    end

    initial begin
        a_r9_ndig_range: assert (NDIG >= 1 && NDIG <= 14 && RES_W == 32)
            else $error("digit count out of range");
    end

    a_r6_vld_rise: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    a_r6_vld_idle: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(out_value) && $stable(out_err)));

    a_r3_bad_digit: assert property (@(posedge clk) disable iff (rst)
        (in_vld && any_bad_dig) |=> out_err);

    a_r4_bad_carry: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_carry == 2'b10) |=> out_err);

    a_r5_legal_clears: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !any_bad_dig && in_carry != 2'b10) |=> !out_err);

    a_r2_carry_pos: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_digits == '0 && in_carry == 2'b01) |=> (out_value == CY_UNIT));

    a_r2_carry_neg: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_digits == '0 && in_carry == 2'b11) |=> (out_value == -CY_UNIT));

    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_vld && out_value == '0 && !out_err));
endmodule

bind sdq2bin_conv sdq2bin_chk #(
    .NDIG (NDIG),
    .RES_W(RES_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_digits(in_digits),
    .in_carry (in_carry),
    .out_vld  (out_vld),
    .out_value(out_value),
    .out_err  (out_err)
);

// File: tb/sim_sdq2bin_conv.sv
`timescale 1ns/1ps
module sim_sdq2bin_conv;
    localparam int NDIG  = 4;
    localparam int RES_W = 32;
    localparam int DW    = 3 * NDIG;

    logic                    clk = 1'b0;
    logic                    rst;
    logic                    in_vld;
    logic [DW-1:0]           in_digits;
    logic [1:0]              in_carry;
    logic                    out_vld;
    logic signed [RES_W-1:0] out_value;
    logic                    out_err;

    int n_cmp = 0;
    int n_bad = 0;

    int    exp_val_q[$];
    logic  exp_err_q[$];
    string exp_tag_q[$];

    always #2.5 clk = ~clk;

    sdq2bin_conv #(.NDIG(NDIG), .RES_W(RES_W)) u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_digits(in_digits),
        .in_carry(in_carry), .out_vld(out_vld), .out_value(out_value),
        .out_err(out_err)
    );

    function automatic void ref_model(input logic [DW-1:0] dg, input logic [1:0] cy,
                                      output int v, output logic e);
        v = 0;
        e = 1'b0;
        for (int i = 0; i < NDIG; i++) begin
            logic signed [2:0] f;
            f = dg[3*i +: 3];
            if (f == -3'sd4) e = 1'b1;
            else v = v + int'(f) * (4 ** i);
        end
        case (cy)
            2'b01:   v = v + (4 ** NDIG);
            2'b11:   v = v - (4 ** NDIG);
            2'b10:   e = 1'b1;
            default: v = v;
        endcase
    endfunction

    function automatic logic [DW-1:0] pack4(input int d3, input int d2, input int d1, input int d0);
        return {3'(d3), 3'(d2), 3'(d1), 3'(d0)};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [DW-1:0] dg, input logic [1:0] cy, input string tag);
        int   v;
        logic e;
        @(negedge clk);
        in_vld    = 1'b1;
        in_digits = dg;
        in_carry  = cy;
        ref_model(dg, cy, v, e);
        exp_val_q.push_back(v);
        exp_err_q.push_back(e);
        exp_tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    // Monitor: compare each produced result against the scoreboard.
    always @(negedge clk) begin
        if (!rst && out_vld) begin
            if (exp_val_q.size() == 0) begin
                check(1'b0, "R6 unexpected result", 1, 0);
            end else begin
                int    v;
                logic  e;
                string t;
                v = exp_val_q.pop_front();
                e = exp_err_q.pop_front();
                t = exp_tag_q.pop_front();
                check(out_value == v, {t, " value"}, out_value, v);
                check(out_err == e, {t, " error flag"}, int'(out_err), int'(e));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int hv;
        logic he;
        rst       = 1'b1;
        in_vld    = 1'b0;
        in_digits = '0;
        in_carry  = 2'b00;
        repeat (3) @(negedge clk);
        // R8: reset state
        check(out_vld == 1'b0, "R8 reset out_vld", int'(out_vld), 0);
        check(out_value == 0, "R8 reset out_value", out_value, 0);
        check(out_err == 1'b0, "R8 reset out_err", int'(out_err), 0);
        rst = 1'b0;

        // R1 / R2: exhaustive legal sweep under each legal carry code
        for (int c = 0; c < 3; c++) begin
            logic [1:0] cy;
            cy = (c == 0) ? 2'b00 : (c == 1) ? 2'b01 : 2'b11;
            for (int a = -3; a <= 3; a++)
                for (int b = -3; b <= 3; b++)
                    for (int d = -3; d <= 3; d++)
                        for (int f = -3; f <= 3; f++)
                            drive(pack4(a, b, d, f), cy, (c == 0) ? "R1" : "R2");
        end

        // R3: illegal digit in each position
        for (int p = 0; p < NDIG; p++) begin
            logic [DW-1:0] dg;
            dg = pack4(1, 1, 1, 1);
            dg[3*p +: 3] = 3'b100;
            drive(dg, 2'b01, "R3");
        end
        // R4: illegal carry code
        drive(pack4(2, -1, 3, -2), 2'b10, "R4");
        drive(pack4(0, 0, 0, 0), 2'b10, "R4");
        // R5: legal transaction right after an illegal one
        drive(pack4(-3, 0, 0, 0), 2'b10, "R4");
        drive(pack4(3, 3, 3, 3), 2'b11, "R5");
        drive(pack4(0, 3'b100 == 3'b100 ? -4 : 0, 0, 0), 2'b00, "R3");
        drive(pack4(-1, -1, -1, -1), 2'b00, "R5");

        // R7 / R6: hold while idle
        drive(pack4(1, -2, 3, -3), 2'b01, "R7 setup");
        ref_model(pack4(1, -2, 3, -3), 2'b01, hv, he);
        @(negedge clk);
        in_vld    = 1'b0;
        in_digits = pack4(-4, -4, 2, 2);
        in_carry  = 2'b10;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(out_vld == 1'b0, "R6 out_vld low when idle", int'(out_vld), 0);
            check(out_value == hv, "R7 value held", out_value, hv);
            check(out_err == he, "R7 flag held", int'(out_err), int'(he));
            in_digits = pack4(k, -k, 3, 0);
        end

        // R8: reset while a transaction is presented
        @(negedge clk);
        rst       = 1'b1;
        in_vld    = 1'b1;
        in_digits = pack4(-4, 1, 1, 1);
        in_carry  = 2'b01;
        @(negedge clk);
        check(out_vld == 1'b0, "R8 mid-run out_vld", int'(out_vld), 0);
        check(out_value == 0, "R8 mid-run out_value", out_value, 0);
        check(out_err == 1'b0, "R8 mid-run out_err", int'(out_err), 0);
        rst    = 1'b0;
        in_vld = 1'b0;

        // R6: one result per accepted transaction
        drive(pack4(0, 0, 0, 1), 2'b00, "R6");
        idle();
        repeat (3) @(negedge clk);
        check(exp_val_q.size() == 0, "R6 all results delivered", exp_val_q.size(), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule